// File: doc/BRIEF.md
# Four-Lane Reversible Serial-to-Parallel Output Driver

This block turns four parallel serial bit streams into one wide bank of static logic outputs. Four equal shift lanes share one clock. Each rising edge moves one new bit into every lane, so a full 80-bit frame loads in 20 edges. A direction input decides which end of each lane takes the new bit. Each lane also has a cascade output, so the next device in a chain can be fed from it.

A hold register sits behind the lanes. While the load-enable level is high, it takes a copy of the lanes. While that level is low, it keeps its word, and the lanes can fill the next frame in the background. An output stage then either shows the held word, shows it inverted, or forces every output to one constant level. That constant is set by the polarity input.

Level shifting and analog drive lie outside this block. Only the synchronous logic is modelled here.

Top module: `sipo_quad_driver`

## Requirements
- R1: A low `rst_n` at a rising edge clears every lane stage and every hold bit to 0. With `unblank`=1 and `pass_true`=1, every `drv_out` bit then reads 0 and every `casc_out` bit reads 0.
- R2: At a rising edge with `dir_fwd`=1, stage 0 of lane L takes `ser_in[L]`, and stage k (k≥1) takes the old value of stage k−1.
- R3: At a rising edge with `dir_fwd`=0, stage 19 of lane L takes `ser_in[L]`, and stage k (k≤18) takes the old value of stage k+1.
- R4: `casc_out[L]` shows stage 19 of lane L while `dir_fwd`=1 and stage 0 while `dir_fwd`=0. It follows the present level of `dir_fwd` with no clock delay.
- R5: Stage k of lane L maps to output bit L·20+k. Lane 0 stage 0 is `drv_out[0]`, and lane 3 stage 19 is `drv_out[79]`.
- R6: After a rising edge where `latch_en`=1, the hold register equals the lane contents written at that same edge.
- R7: At a rising edge where `latch_en`=0, the hold register keeps its value, even while the lanes shift.
- R8: `unblank`=0 with `pass_true`=0 drives every `drv_out` bit to 1.
- R9: `unblank`=0 with `pass_true`=1 drives every `drv_out` bit to 0.
- R10: With `unblank`=1, `drv_out` equals the hold register when `pass_true`=1 and its bitwise inverse when `pass_true`=0. Changes take effect without a clock edge.
- R11: `latch_en`, `unblank` and `pass_true` do not alter how the lanes shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and hold clock, rising edge |
| rst_n | input | 1 | Active-low synchronous clear |
| ser_in | input | 4 | One serial data bit per lane |
| dir_fwd | input | 1 | 1 = shift toward stage 19, 0 = shift toward stage 0 |
| latch_en | input | 1 | Hold register loads on each edge while high |
| unblank | input | 1 | 0 forces all outputs to a constant |
| pass_true | input | 1 | Output polarity: 1 = true data, 0 = inverted |
| casc_out | output | 4 | Per-lane cascade output from the exit stage |
| drv_out | output | 80 | Parallel driver outputs |

## Verification
Four groups of rules are checked by the assertions on every clock: the stage-to-stage moves in both directions, the load of the hold register and its stability while loading is off, and the three output forms. Other behaviour can only be seen through the bench's scenarios. These are the mapping of lane stages onto output bit numbers, the cascade pin switching ends when the direction flips, and the bank showing the intended frame after a full 20-edge load. The bench also confirms that the blanking and polarity levels change while loading is off leave the next frame's shifting unchanged.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  // One output bit: a blanked bit reads as ~pol, otherwise data is XORed with ~pol.
  function automatic logic drive_bit(input logic held, input logic show, input logic pol);
    return (held & show) ^ ~pol;
  endfunction

  // Exit stage of a lane depends on direction.
  function automatic logic exit_bit(input logic fwd, input logic hi_end, input logic lo_end);
    return fwd ? hi_end : lo_end;
  endfunction

endpackage

// File: rtl/sipo_lane.sv
module sipo_lane #(
  parameter int STAGES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd,
  input  logic              din,
  output logic [STAGES-1:0] q,
  output logic [STAGES-1:0] nxt,
  output logic              dout
);
  import sipo_pkg::*;

  always_comb begin
    if (fwd) nxt = {q[STAGES-2:0], din};
    else     nxt = {din, q[STAGES-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign dout = exit_bit(fwd, q[STAGES-1], q[0]);

  // R2: forward entry and step
  assert_fwd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && fwd) |=> (q[0] == $past(din)));
  assert_fwd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && fwd) |=> (q[STAGES-1:1] == $past(q[STAGES-2:0])));
  // R3: reverse entry and step
  assert_rev_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !fwd) |=> (q[STAGES-1] == $past(din)));
  assert_rev_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !fwd) |=> (q[STAGES-2:0] == $past(q[STAGES-1:1])));

endmodule

// File: rtl/sipo_hold.sv
module sipo_hold #(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R7: no load keeps the held word
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !load) |=> $stable(q));

endmodule

// File: rtl/sipo_outstage.sv
module sipo_outstage #(
  parameter int W = 80
) (
  input  logic [W-1:0] held,
  input  logic         show,
  input  logic         pol,
  output logic [W-1:0] drv
);
  import sipo_pkg::*;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign drv[b] = drive_bit(held[b], show, pol);
  end

endmodule

// File: rtl/sipo_quad_driver.sv
module sipo_quad_driver #(
  parameter int LANES  = 4,
  parameter int STAGES = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         ser_in,
  input  logic                     dir_fwd,
  input  logic                     latch_en,
  input  logic                     unblank,
  input  logic                     pass_true,
  output logic [LANES-1:0]         casc_out,
  output logic [LANES*STAGES-1:0]  drv_out
);
  localparam int W = LANES * STAGES;

  // Named internal events for the assertions.
  logic [W-1:0] shift_flat;
  logic [W-1:0] shift_next;
  logic [W-1:0] held_word;

  // Lane L stage k sits at flat bit L*STAGES+k (R5).
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sipo_lane #(.STAGES(STAGES)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .fwd  (dir_fwd),
      .din  (ser_in[g]),
      .q    (shift_flat[g*STAGES +: STAGES]),
      .nxt  (shift_next[g*STAGES +: STAGES]),
      .dout (casc_out[g])
    );
  end

  // Edge-loaded hold: takes the value the lanes get at the same edge.
  sipo_hold #(.W(W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (latch_en),
    .d    (shift_next),
    .q    (held_word)
  );

  sipo_outstage #(.W(W)) u_out (
    .held(held_word),
    .show(unblank),
    .pol (pass_true),
    .drv (drv_out)
  );

  // R6: after a loading edge the hold equals the lanes
  assert_hold_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && latch_en) |=> (held_word == shift_flat));
  // R8: blanked, inverted polarity -> all ones
  assert_blank_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!unblank && !pass_true) |-> (&drv_out));
  // R9: blanked, true polarity -> all zeros
  assert_blank_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!unblank && pass_true) |-> (drv_out == '0));
  // R10: shown data, both polarities
  assert_show_true_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (unblank && pass_true) |-> (drv_out == held_word));
  assert_show_inv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (unblank && !pass_true) |-> (drv_out == ~held_word));

endmodule

// File: tb/test_sipo_quad_driver.sv
module test_sipo_quad_driver;
  localparam int LANES = 4;
  localparam int STAGES = 20;
  localparam int W = LANES * STAGES;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic [LANES-1:0] ser_in;
  logic             dir_fwd, latch_en, unblank, pass_true;
  logic [LANES-1:0] casc_out;
  logic [W-1:0]     drv_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [W-1:0] m_sh, m_lat;

  sipo_quad_driver #(.LANES(LANES), .STAGES(STAGES)) i_sipo_quad_driver (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .dir_fwd(dir_fwd),
    .latch_en(latch_en), .unblank(unblank), .pass_true(pass_true),
    .casc_out(casc_out), .drv_out(drv_out)
  );

  function automatic logic [3:0] pat(input int i);
    return 4'((i * 5 + 3) ^ (i >> 2) ^ (i * i));
  endfunction

  function automatic logic [W-1:0] exp_drv();
    if (!unblank) return pass_true ? '0 : '1;
    return pass_true ? m_lat : ~m_lat;
  endfunction

  function automatic logic [LANES-1:0] exp_casc();
    logic [LANES-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l] = dir_fwd ? m_sh[l*STAGES + STAGES-1] : m_sh[l*STAGES];
    return r;
  endfunction

  task automatic check(input string req);
    n_cmp++;
    if (drv_out !== exp_drv()) begin
      n_bad++;
      $display("FAIL %s drv_out actual=%h expected=%h", req, drv_out, exp_drv());
    end
    n_cmp++;
    if (casc_out !== exp_casc()) begin
      n_bad++;
      $display("FAIL %s casc_out actual=%b expected=%b", req, casc_out, exp_casc());
    end
  endtask

  task automatic tick(input logic [3:0] s, input logic d, input logic le);
    ser_in = s; dir_fwd = d; latch_en = le;
    @(posedge clk);
    if (!rst_n) begin
      m_sh = '0; m_lat = '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (d) begin
          for (int k = STAGES-1; k > 0; k--) m_sh[l*STAGES+k] = m_sh[l*STAGES+k-1];
          m_sh[l*STAGES] = s[l];
        end else begin
          for (int k = 0; k < STAGES-1; k++) m_sh[l*STAGES+k] = m_sh[l*STAGES+k+1];
          m_sh[l*STAGES+STAGES-1] = s[l];
        end
      end
      if (le) m_lat = m_sh;
    end
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ser_in = '1; dir_fwd = 1; latch_en = 1; unblank = 1; pass_true = 1;
    m_sh = '0; m_lat = '0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;

    // Forward full-frame load, hold transparent (R2 R5 R6 R4)
    for (int i = 0; i < STAGES; i++) begin
      tick(pat(i), 1'b1, 1'b1);
      check("R2 R4 R6");
    end
    // R5: explicit mapping of frame bits to output numbers
    n_cmp++;
    if (drv_out[0] !== pat(STAGES-1)[0]) begin
      n_bad++; $display("FAIL R5 drv_out[0] actual=%b expected=%b", drv_out[0], pat(STAGES-1)[0]);
    end
    n_cmp++;
    if (drv_out[W-1] !== pat(0)[3]) begin
      n_bad++; $display("FAIL R5 drv_out[79] actual=%b expected=%b", drv_out[W-1], pat(0)[3]);
    end
    n_cmp++;
    if (drv_out[2*STAGES+5] !== pat(STAGES-1-5)[2]) begin
      n_bad++; $display("FAIL R5 drv_out[45] actual=%b expected=%b",
                        drv_out[2*STAGES+5], pat(STAGES-6)[2]);
    end

    // Shift with hold closed, toggling blank/polarity (R7 R11)
    for (int i = 0; i < 12; i++) begin
      unblank = i[1]; pass_true = i[0];
      tick(pat(i + 40), 1'b1, 1'b0);
      check("R7 R11");
    end

    // Four output modes on the held word (R8 R9 R10)
    unblank = 0; pass_true = 0; #1; check("R8");
    unblank = 0; pass_true = 1; #1; check("R9");
    unblank = 1; pass_true = 1; #1; check("R10");
    unblank = 1; pass_true = 0; #1; check("R10");

    // Reverse shifting, inverted shown data (R3 R4)
    for (int i = 0; i < 30; i++) begin
      tick(pat(i + 70), 1'b0, 1'b1);
      check("R3 R4");
    end
    // Direction flip per edge: cascade end changes at once (R4)
    for (int i = 0; i < 16; i++) begin
      tick(pat(i + 110), i[0], i[2]);
      check("R2 R3 R4");
      dir_fwd = ~dir_fwd; #1; check("R4");
    end

    // Synchronous reset mid-run (R1)
    unblank = 1; pass_true = 1;
    rst_n = 0;
    tick(4'hF, 1'b1, 1'b1);
    check("R1");
    rst_n = 1;
    tick(4'h5, 1'b0, 1'b1);
    check("R3 R6");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule